// File: doc/BRIEF.md
# Tiled Unsigned Multiply-Add Array

This block multiplies two unsigned operands and adds a third unsigned operand to the product, all in one combinational pass with no clock and no stored state. It is assembled from a single kind of leaf cell that takes 2-bit digits. Each cell multiplies one multiplicand digit by one multiplier digit and adds two more 2-bit digits in the same step. Because of this, the array is built by wiring identical cells together. No separate adder tree and no glue logic are needed.

The operands are split into 2-bit digits. Each row of cells handles one multiplier digit. Inside a row, the digits of the multiplicand ripple a 2-bit carry from the low end to the high end. Each row passes its partial sum down to the next row, shifted by one digit. The external addend enters through the otherwise unused digit inputs of the first row. The user sets the operand widths with even parameters of at least 2.

Top module: `mac_array`

## Requirements
- R1: A single cell returns the 4-bit value s = a*b + k + m for every combination of its four 2-bit unsigned inputs. The worst case, 3*3+3+3 = 15, still fits in the 4 bits, so s never wraps.
- R2: A single cell with a=2, b=3, k=1 and m=2 returns s = 9 (binary 1001).
- R3: The array output p, which is WX+WY bits wide, equals x*y + addend exactly for every unsigned x, y and addend. This result never needs more than WX+WY bits.
- R4: When addend is 0, p equals the plain product x*y.
- R5: When x is 0 or y is 0, p equals addend, zero-extended.
- R6: When y is 1, p equals x + addend.
- R7: When x, y and addend are all ones, p equals (2^WX-1)*(2^WY-1) + 2^WX-1. This is the largest value the array can produce.
- R8: The multiplicand and multiplier widths may differ. For example, a 6-bit by 4-bit array obeys R3 in the same way as a square array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WX | Unsigned multiplicand |
| y | input | WY | Unsigned multiplier |
| addend | input | WX | Unsigned value added to the product |
| p | output | WX+WY | x*y + addend |

## Verification
The bound checker re-evaluates the arithmetic identity of R3 whenever an input changes. It also checks the special forms of that identity: R4 when the addend is zero, R5 when an operand is zero, R6 for a unit multiplier and R7 when every input is all ones. These are checked on every input pattern the array ever sees. The leaf cell's own table (R1, R2) can only be shown by the bench's exhaustive sweep of a standalone cell. The bench also sweeps every input of a 4-bit by 4-bit array and drives random patterns into 8x8 and 6x4 arrays. Those scenarios are what show that the digit routing between rows is right for square and non-square shapes (R8).

// File: rtl/mac_pkg.sv
// Package: shared digit type and width helpers for the multiply-add array.
// Assumes every operand width is a multiple of the digit width.
package mac_pkg;
    localparam int DIGIT_W = 2;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Number of 2-bit digits in an operand of the given width.
    function automatic int digits_of(input int width);
        return width / DIGIT_W;
    endfunction
endpackage

// File: rtl/mac_cell.sv
// Module: mac_cell
// Leaf multiply-add element. It forms a*b + k + m on 2-bit unsigned digits.
// Assumes unsigned inputs. The 4-bit result cannot overflow, since 15 is the
// largest reachable value. The low digit of s is the sum digit and the high
// digit of s is the carry digit.
module mac_cell
    import mac_pkg::*;
(
    input  digit_t     a,
    input  digit_t     b,
    input  digit_t     k,
    input  digit_t     m,
    output logic [3:0] s
);
    logic [3:0] prod;

    // Form the 2x2 product from shifted partial products.
    always_comb begin
        prod = ({2'b00, a} & {4{b[0]}})
             + ({1'b0, a, 1'b0} & {4{b[1]}});
    end

    // Add both addend digits to the product.
    always_comb begin
        s = prod + {2'b00, k} + {2'b00, m};
    end
endmodule

// File: rtl/mac_row.sv
// Module: mac_row
// One row of cells. It multiplies the whole multiplicand by one multiplier
// digit and adds an incoming digit vector. A 2-bit carry ripples from the
// lowest cell to the highest.
// Assumes NX >= 1. sum_lo holds the low digit of each cell, and cout is the
// carry out of the top cell, which sits one digit above sum_lo.
module mac_row
    import mac_pkg::*;
#(
    parameter int NX = 2,
    localparam int W = NX * DIGIT_W
) (
    input  logic [W-1:0] x,
    input  digit_t       yd,
    input  logic [W-1:0] kin,
    output logic [W-1:0] sum_lo,
    output digit_t       cout
);
    digit_t carry [NX+1];

    // The chain enters with no carry.
    assign carry[0] = '0;

    for (genvar j = 0; j < NX; j++) begin : g_col
        logic [3:0] cs;

        mac_cell u_cell (
            .a (x[DIGIT_W*j +: DIGIT_W]),
            .b (yd),
            .k (kin[DIGIT_W*j +: DIGIT_W]),
            .m (carry[j]),
            .s (cs)
        );

        // Split the cell result into its sum digit and its carry digit.
        assign sum_lo[DIGIT_W*j +: DIGIT_W] = cs[1:0];
        assign carry[j+1]                   = cs[3:2];
    end

    assign cout = carry[NX];
endmodule

// File: rtl/mac_array.sv
// Module: mac_array
// Unsigned WX-by-WY multiplier that adds addend to the product.
// Assumes WX and WY are even and at least 2. Purely combinational.
// Row i handles multiplier digit i. Its lowest sum digit is product digit i,
// and its remaining digits plus its carry feed row i+1 one digit lower.
// The last row supplies the upper WX bits of p.
module mac_array
    import mac_pkg::*;
#(
    parameter int WX = 8,
    parameter int WY = 8,
    localparam int NX = digits_of(WX),
    localparam int NY = digits_of(WY),
    localparam int WP = WX + WY
) (
    input  logic [WX-1:0] x,
    input  logic [WY-1:0] y,
    input  logic [WX-1:0] addend,
    output logic [WP-1:0] p
);
    logic [WX-1:0] row_k [NY];
    logic [WX-1:0] row_s [NY];
    digit_t        row_c [NY];

    // The external addend enters the free digit inputs of the first row.
    assign row_k[0] = addend;

    for (genvar i = 0; i < NY; i++) begin : g_row
        mac_row #(.NX(NX)) u_row (
            .x      (x),
            .yd     (y[DIGIT_W*i +: DIGIT_W]),
            .kin    (row_k[i]),
            .sum_lo (row_s[i]),
            .cout   (row_c[i])
        );

        // The lowest sum digit of each row is final.
        assign p[DIGIT_W*i +: DIGIT_W] = row_s[i][DIGIT_W-1:0];

        if (i + 1 < NY) begin : g_link
            // Pass the upper digits and the carry down one digit.
            if (NX > 1) begin : g_wide
                assign row_k[i+1] = {row_c[i], row_s[i][WX-1:DIGIT_W]};
            end else begin : g_narrow
                assign row_k[i+1] = row_c[i];
            end
        end else begin : g_last
            // The last row supplies the upper part of the result.
            if (NX > 1) begin : g_wide
                assign p[WP-1:WY] = {row_c[i], row_s[i][WX-1:DIGIT_W]};
            end else begin : g_narrow
                assign p[WP-1:WY] = row_c[i];
            end
        end
    end
endmodule

// File: rtl/mac_array_chk.sv
// Module: mac_array_chk
// Checker bound to mac_array. It tests the result against arithmetic
// identities whenever an input changes. Assumes the array has settled
// combinationally before the check runs.
module mac_array_chk #(
    parameter int WX = 8,
    parameter int WY = 8,
    localparam int WP = WX + WY
) (
    input logic [WX-1:0] x,
    input logic [WY-1:0] y,
    input logic [WX-1:0] addend,
    input logic [WP-1:0] p
);
    logic [WP:0] ref_full;
    logic [WP:0] max_val;

    // Reference value, one bit wider than p so that a wrap would show.
    always_comb begin
        ref_full = {{(WP+1-WX){1'b0}}, x} * {{(WP+1-WY){1'b0}}, y}
                 + {{(WP+1-WX){1'b0}}, addend};
        max_val  = (((WP+1)'(1) << WX) - 1) * (((WP+1)'(1) << WY) - 1)
                 + (((WP+1)'(1) << WX) - 1);
    end

    // Check the identities on every input pattern.
    always_comb begin
        assert_sum_matches_R3: assert ({1'b0, p} == ref_full)
            else $error("R3: p=%0d expected %0d", p, ref_full);
        if (addend == '0) begin
            assert_pure_product_R4: assert (p == WP'(x) * WP'(y))
                else $error("R4: p=%0d", p);
        end
        if (x == '0 || y == '0) begin
            assert_zero_operand_R5: assert (p == WP'(addend))
                else $error("R5: p=%0d", p);
        end
        if (y == WY'(1)) begin
            assert_unit_multiplier_R6: assert (p == WP'(x) + WP'(addend))
                else $error("R6: p=%0d", p);
        end
        if (&x && &y && &addend) begin
            assert_all_ones_R7: assert ({1'b0, p} == max_val)
                else $error("R7: p=%0d", p);
        end
    end
endmodule

bind mac_array mac_array_chk #(.WX(WX), .WY(WY)) u_chk (
    .x      (x),
    .y      (y),
    .addend (addend),
    .p      (p)
);

// File: tb/test_mac_array.sv
// Bench for mac_array and mac_cell. It sweeps a standalone cell and a 4x4
// array exhaustively, and drives random patterns into 8x8 and 6x4 arrays.
module test_mac_array;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Standalone cell.
    logic [1:0] ca, cb, ck, cm;
    logic [3:0] cs;
    mac_cell i_mac_cell (.a(ca), .b(cb), .k(ck), .m(cm), .s(cs));

    // 4x4 array.
    logic [3:0] x4, y4, a4;
    logic [7:0] p4;
    mac_array #(.WX(4), .WY(4)) i_mac_array (.x(x4), .y(y4), .addend(a4), .p(p4));

    // 8x8 array.
    logic [7:0]  x8, y8, a8;
    logic [15:0] p8;
    mac_array #(.WX(8), .WY(8)) i_mac_array_8 (.x(x8), .y(y8), .addend(a8), .p(p8));

    // 6x4 array.
    logic [5:0] x6, a6;
    logic [3:0] y6;
    logic [9:0] p6;
    mac_array #(.WX(6), .WY(4)) i_mac_array_64 (.x(x6), .y(y6), .addend(a6), .p(p6));

    // Record one comparison.
    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        ca = 0; cb = 0; ck = 0; cm = 0;
        x4 = 0; y4 = 0; a4 = 0;
        x8 = 0; y8 = 0; a8 = 0;
        x6 = 0; y6 = 0; a6 = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle inputs give a zero result.
        check("R5 idle", p4, 0);

        // R2: worked example for the cell.
        @(posedge clk); ca = 2; cb = 3; ck = 1; cm = 2;
        @(negedge clk); check("R2", cs, 9);

        // R1: exhaustive sweep of the cell.
        for (int v = 0; v < 256; v++) begin
            @(posedge clk);
            {ca, cb, ck, cm} = 8'(v);
            @(negedge clk);
            check("R1", cs, ca * cb + ck + cm);
        end

        // R3, R4, R5, R6: exhaustive sweep of the 4x4 array.
        for (int v = 0; v < 4096; v++) begin
            @(posedge clk);
            {x4, y4, a4} = 12'(v);
            @(negedge clk);
            if (a4 == 0)            check("R4", p4, x4 * y4);
            else if (x4 == 0 || y4 == 0) check("R5", p4, a4);
            else if (y4 == 1)       check("R6", p4, x4 + a4);
            else                    check("R3", p4, x4 * y4 + a4);
        end

        // R7: all-ones corners.
        @(posedge clk); x8 = 8'hFF; y8 = 8'hFF; a8 = 8'hFF;
        x6 = 6'h3F; y6 = 4'hF; a6 = 6'h3F;
        @(negedge clk);
        check("R7 8x8", p8, 255 * 255 + 255);
        check("R7 6x4", p6, 63 * 15 + 63);

        // R3 and R8: random patterns on the 8x8 and 6x4 arrays.
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk);
            x8 = 8'($urandom); y8 = 8'($urandom); a8 = 8'($urandom);
            x6 = 6'($urandom); y6 = 4'($urandom); a6 = 6'($urandom);
            @(negedge clk);
            check("R3 8x8", p8, x8 * y8 + a8);
            check("R8 6x4", p6, x6 * y6 + a6);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule